// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Overflow Policy

This block turns one floating-point operand, either binary32 or binary64, into a 32-bit or 64-bit integer, signed or unsigned. A 3-bit mode picks two things. The first is the rounding source: the supplied rounding mode, or forced truncation. The second is how NaN, infinity and out-of-range values are handled. Two policies saturate: one maps NaN to the type minimum, the other maps NaN to zero. The third policy wraps the rounded value modulo 2^N and maps NaN and infinity to zero.

The converter has a single register stage. A request presented with `in_valid` produces `out_valid` and the 64-bit result on the next cycle. A 32-bit result is extended to 64 bits according to its signedness. Mode values 110 and 111 are rejected. For these the block raises `out_illegal` instead of `out_valid` and leaves the result register untouched. Exception status flags are not produced.

Top module: `fp2int_cvt`

## Requirements
- R1: A request with `in_valid` high and a legal mode gives `out_valid` high with the result exactly one clock later. With `in_valid` low, neither `out_valid` nor `out_illegal` rises on the next cycle, and the result is held.
- R2: Mode 110 or 111 with `in_valid` gives `out_illegal` high and `out_valid` low one cycle later, and `out_result` keeps its previous value.
- R3: `in_fmt_dp`=1 treats all 64 bits of `in_op` as binary64. `in_fmt_dp`=0 treats `in_op[31:0]` as binary32, and `in_op[63:32]` has no effect.
- R4: In modes 000, 010 and 100, `in_rm` selects the rounding: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. In modes 001, 011 and 101, the value is always truncated toward zero.
- R5: In modes 000 to 011, a non-NaN operand whose rounded value exceeds the destination maximum returns the maximum. One whose rounded value is below the destination minimum returns the minimum; infinities count as out of range. Any other value returns the rounded value.
- R6: In modes 000 and 001, a NaN returns the destination minimum: -2^(N-1) for signed, 0 for unsigned.
- R7: In modes 010 and 011, a NaN returns 0.
- R8: In modes 100 and 101, NaN and infinity return 0. Any other value is rounded, and the low N bits of its two's-complement form are returned.
- R9: A 32-bit result (`in_dst64`=0) is sign-extended to 64 bits when `in_signed`=1 and zero-extended when `in_signed`=0.
- R10: Zeros of either sign and subnormals give 0, except that rounding toward +infinity gives +1 for a positive nonzero subnormal, and rounding toward -infinity gives -1 for a negative one.
- R11: For unsigned destinations in the saturating modes, a negative operand gives 0. This covers one that rounds to a nonzero value and negative infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 64 | Floating-point operand |
| in_fmt_dp | input | 1 | 1: binary64 operand, 0: binary32 in low half |
| in_dst64 | input | 1 | 1: 64-bit destination, 0: 32-bit |
| in_signed | input | 1 | 1: signed destination |
| in_mode | input | 3 | Rounding source and overflow policy |
| in_rm | input | 2 | Rounding mode used by even modes |
| out_result | output | 64 | Converted integer |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Illegal-mode indication |

## Verification
A flaw in this block is purely combinational up to its one register, so every fault appears in `out_result` on the cycle right after the request. A wrong alignment shift shows up as a factor-of-two error on exactly representable operands. A wrong round increment shows up as off-by-one results on ties and directed-rounding cases. A swapped limit shows up as wrong saturation values at ±2^63, 2^64 and infinities. A broken wrap path shows up when values beyond 2^32 keep only their low bits, or fail to. The NaN policy and the illegal-mode handling are visible through the result and the two strobes on that same cycle.

// File: rtl/fp2int_cvt.sv
module fp2int_cvt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_op,
  input  logic        in_fmt_dp,
  input  logic        in_dst64,
  input  logic        in_signed,
  input  logic [2:0]  in_mode,
  input  logic [1:0]  in_rm,
  output logic [63:0] out_result,
  output logic        out_valid,
  output logic        out_illegal
);

  wire [10:0] exp_d = in_op[62:52];
  wire [7:0]  exp_s = in_op[30:23];
  wire        legal = ~(in_mode[2] & in_mode[1]);

  logic               sgn, is_nan, is_inf;
  logic signed [12:0] e, sh;
  logic [52:0]        m;

  always_comb begin
    if (in_fmt_dp) begin
      sgn    = in_op[63];
      m      = {|exp_d, in_op[51:0]};
      e      = (exp_d == 11'd0) ? -13'sd1022 : $signed({2'b00, exp_d}) - 13'sd1023;
      is_nan = (&exp_d) & (|in_op[51:0]);
      is_inf = (&exp_d) & ~(|in_op[51:0]);
    end else begin
      sgn    = in_op[31];
      m      = {|exp_s, in_op[22:0], 29'd0};
      e      = (exp_s == 8'd0) ? -13'sd126 : $signed({5'd0, exp_s}) - 13'sd127;
      is_nan = (&exp_s) & (|in_op[22:0]);
      is_inf = (&exp_s) & ~(|in_op[22:0]);
    end
    sh = e - 13'sd52;
  end

  logic [116:0] fx;
  logic [63:0]  ip;
  logic [6:0]   rs;
  logic         rnd, stk, big;

  always_comb begin
    big = (e >= 13'sd64);
    rs  = 7'd0;
    fx  = '0;
    if (sh >= 13'sd0) begin
      ip  = (sh >= 13'sd64) ? 64'd0 : ({11'd0, m} << sh[5:0]);
      rnd = 1'b0;
      stk = 1'b0;
    end else begin
      rs  = (sh < -13'sd54) ? 7'd54 : 7'(-sh);
      fx  = {m, 64'd0} >> rs;
      ip  = 64'(fx[116:64]);
      rnd = fx[63];
      stk = |fx[62:0];
    end
  end

  wire [1:0] rm = in_mode[0] ? 2'b01 : in_rm;
  logic inc;
  always_comb begin
    case (rm)
      2'b00:   inc = rnd & (stk | ip[0]);
      2'b10:   inc = ~sgn & (rnd | stk);
      2'b11:   inc = sgn & (rnd | stk);
      default: inc = 1'b0;
    endcase
  end

  wire [64:0] mag  = {1'b0, ip} + 65'(inc);
  wire        huge = big | is_inf | mag[64];
  wire [63:0] sval = sgn ? -mag[63:0] : mag[63:0];

  logic [64:0] pos_lim, neg_lim;
  logic [63:0] max_v, min_v;
  always_comb begin
    case ({in_dst64, in_signed})
      2'b00: begin pos_lim = 65'h0_FFFF_FFFF;           neg_lim = '0;
                   max_v = 64'h0000_0000_FFFF_FFFF;     min_v = '0; end
      2'b01: begin pos_lim = 65'h0_7FFF_FFFF;           neg_lim = 65'h0_8000_0000;
                   max_v = 64'h0000_0000_7FFF_FFFF;     min_v = 64'hFFFF_FFFF_8000_0000; end
      2'b10: begin pos_lim = {1'b0, {64{1'b1}}};        neg_lim = '0;
                   max_v = {64{1'b1}};                  min_v = '0; end
      default: begin pos_lim = {2'b00, {63{1'b1}}};     neg_lim = {2'b01, 63'd0};
                   max_v = {1'b0, {63{1'b1}}};          min_v = {1'b1, 63'd0}; end
    endcase
  end

  wire [63:0] wrap_v = in_dst64  ? sval :
                       in_signed ? {{32{sval[31]}}, sval[31:0]} : {32'd0, sval[31:0]};

  logic [63:0] res;
  always_comb begin
    if (in_mode[2])                        res = (is_nan | is_inf) ? 64'd0 : wrap_v;
    else if (is_nan)                       res = in_mode[1] ? 64'd0 : min_v;
    else if (!sgn && (huge || mag > pos_lim)) res = max_v;
    else if (sgn && (huge || mag > neg_lim))  res = min_v;
    else                                   res = sval;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_result  <= '0;
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid & legal;
      out_illegal <= in_valid & ~legal;
      if (in_valid && legal) out_result <= res;
    end
  end

endmodule

// File: rtl/fp2int_cvt_chk.sv
module fp2int_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_op,
  input logic        in_fmt_dp,
  input logic        in_dst64,
  input logic        in_signed,
  input logic [2:0]  in_mode,
  input logic [63:0] out_result,
  input logic        out_valid,
  input logic        out_illegal
);

  wire bad_mode = in_mode[2] & in_mode[1];
  wire dp_nan   = in_fmt_dp & (&in_op[62:52]) & (|in_op[51:0]);
  wire dp_spec  = in_fmt_dp & (&in_op[62:52]);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !bad_mode |=> out_valid && !out_illegal);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_illegal && $stable(out_result));

  assert_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && bad_mode |=> out_illegal && !out_valid && $stable(out_result));

  assert_nan_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode[2:1] == 2'b01 && dp_nan |=> out_result == 64'd0);

  assert_wrap_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode[2:1] == 2'b10 && dp_spec |=> out_result == 64'd0);

  assert_sext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !bad_mode && !in_dst64 && in_signed |=> out_result[63:32] == {32{out_result[31]}});

  assert_zext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !bad_mode && !in_dst64 && !in_signed |=> out_result[63:32] == 32'd0);

endmodule

bind fp2int_cvt fp2int_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_fmt_dp(in_fmt_dp), .in_dst64(in_dst64), .in_signed(in_signed),
  .in_mode(in_mode), .out_result(out_result), .out_valid(out_valid),
  .out_illegal(out_illegal)
);

// File: tb/tb_fp2int_cvt.sv
module tb_fp2int_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic        in_fmt_dp = 1'b0, in_dst64 = 1'b0, in_signed = 1'b0;
  logic [2:0]  in_mode = '0;
  logic [1:0]  in_rm = '0;
  logic [63:0] out_result;
  logic        out_valid, out_illegal;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp2int_cvt dut (.*);

  // {dp, dst64, signed, mode, rm, operand, expected, requirement}
  localparam int NV = 39;
  localparam logic [139:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,3'd0,2'd0,64'h3FF8000000000000,64'h0000000000000002,4'd4}, // R4 1.5 RNE
    {1'b1,1'b1,1'b1,3'd0,2'd0,64'h4004000000000000,64'h0000000000000002,4'd4}, // R4 2.5 RNE
    {1'b1,1'b1,1'b1,3'd0,2'd2,64'h4004000000000000,64'h0000000000000003,4'd4}, // R4 2.5 up
    {1'b1,1'b1,1'b1,3'd0,2'd3,64'hC004000000000000,64'hFFFFFFFFFFFFFFFD,4'd4}, // R4 -2.5 down
    {1'b1,1'b1,1'b1,3'd0,2'd0,64'hC004000000000000,64'hFFFFFFFFFFFFFFFE,4'd4}, // R4 -2.5 RNE
    {1'b1,1'b1,1'b1,3'd0,2'd1,64'h4004000000000000,64'h0000000000000002,4'd4}, // R4 2.5 RZ
    {1'b1,1'b1,1'b1,3'd1,2'd2,64'h4004000000000000,64'h0000000000000002,4'd4}, // R4 truncate mode
    {1'b0,1'b1,1'b1,3'd0,2'd0,64'hDEADBEEF3FC00000,64'h0000000000000002,4'd3}, // R3 sp 1.5 high garbage
    {1'b0,1'b1,1'b1,3'd0,2'd3,64'h00000000C0200000,64'hFFFFFFFFFFFFFFFD,4'd3}, // R3 sp -2.5 down
    {1'b1,1'b1,1'b1,3'd0,2'd0,64'h43E0000000000000,64'h7FFFFFFFFFFFFFFF,4'd5}, // R5 2^63 s64
    {1'b1,1'b1,1'b0,3'd0,2'd0,64'h43E0000000000000,64'h8000000000000000,4'd5}, // R5 2^63 u64
    {1'b1,1'b1,1'b1,3'd0,2'd0,64'hC3E0000000000000,64'h8000000000000000,4'd5}, // R5 -2^63 s64
    {1'b1,1'b0,1'b1,3'd2,2'd0,64'h41F0000000500000,64'h000000007FFFFFFF,4'd5}, // R5 2^32+5 s32
    {1'b1,1'b0,1'b1,3'd2,2'd0,64'hFFF0000000000000,64'hFFFFFFFF80000000,4'd5}, // R5 -inf s32
    {1'b1,1'b1,1'b1,3'd0,2'd0,64'h7FF0000000000000,64'h7FFFFFFFFFFFFFFF,4'd5}, // R5 inf s64
    {1'b1,1'b1,1'b0,3'd0,2'd0,64'h43F0000000000000,64'hFFFFFFFFFFFFFFFF,4'd5}, // R5 2^64 u64
    {1'b1,1'b1,1'b0,3'd0,2'd0,64'h41F0000000500000,64'h0000000100000005,4'd5}, // R5 in range u64
    {1'b1,1'b0,1'b1,3'd0,2'd0,64'h7FF8000000000000,64'hFFFFFFFF80000000,4'd6}, // R6 NaN s32
    {1'b1,1'b1,1'b0,3'd1,2'd0,64'h7FF8000000000000,64'h0000000000000000,4'd6}, // R6 NaN u64
    {1'b0,1'b1,1'b1,3'd0,2'd0,64'h000000007FC00000,64'h8000000000000000,4'd6}, // R6 sp NaN s64
    {1'b1,1'b0,1'b1,3'd2,2'd0,64'h7FF8000000000000,64'h0000000000000000,4'd7}, // R7 NaN s32
    {1'b1,1'b1,1'b1,3'd3,2'd0,64'h7FF8000000000000,64'h0000000000000000,4'd7}, // R7 NaN s64
    {1'b1,1'b0,1'b1,3'd4,2'd0,64'h41DFFFFFFFE00000,64'hFFFFFFFF80000000,4'd8}, // R8 round then wrap
    {1'b1,1'b0,1'b1,3'd5,2'd0,64'h41DFFFFFFFE00000,64'h000000007FFFFFFF,4'd8}, // R8 truncate wrap
    {1'b1,1'b0,1'b1,3'd4,2'd0,64'h41F0000000500000,64'h0000000000000005,4'd8}, // R8 2^32+5 wraps
    {1'b1,1'b1,1'b1,3'd4,2'd0,64'h43F0000000000000,64'h0000000000000000,4'd8}, // R8 2^64 wraps
    {1'b1,1'b1,1'b1,3'd4,2'd0,64'h7FF0000000000000,64'h0000000000000000,4'd8}, // R8 inf
    {1'b1,1'b1,1'b1,3'd5,2'd0,64'h7FF8000000000000,64'h0000000000000000,4'd8}, // R8 NaN
    {1'b1,1'b1,1'b1,3'd4,2'd0,64'h43E0000000000000,64'h8000000000000000,4'd8}, // R8 2^63 s64
    {1'b1,1'b0,1'b0,3'd4,2'd0,64'hBFF8000000000000,64'h00000000FFFFFFFE,4'd9}, // R9 u32 zext
    {1'b1,1'b0,1'b1,3'd0,2'd0,64'hBFF8000000000000,64'hFFFFFFFFFFFFFFFE,4'd9}, // R9 s32 sext
    {1'b1,1'b0,1'b0,3'd0,2'd0,64'h41E0000000000000,64'h0000000080000000,4'd9}, // R9 2^31 u32
    {1'b1,1'b1,1'b1,3'd0,2'd0,64'h0000000000000001,64'h0000000000000000,4'd10}, // R10 subnormal RNE
    {1'b1,1'b1,1'b1,3'd0,2'd2,64'h0000000000000001,64'h0000000000000001,4'd10}, // R10 subnormal up
    {1'b1,1'b1,1'b1,3'd0,2'd3,64'h8000000000000001,64'hFFFFFFFFFFFFFFFF,4'd10}, // R10 -subnormal down
    {1'b1,1'b1,1'b1,3'd0,2'd3,64'h8000000000000000,64'h0000000000000000,4'd10}, // R10 -0 down
    {1'b1,1'b0,1'b0,3'd0,2'd0,64'hBFE0000000000000,64'h0000000000000000,4'd11}, // R11 -0.5 u32
    {1'b1,1'b1,1'b0,3'd0,2'd0,64'hBFF8000000000000,64'h0000000000000000,4'd11}, // R11 -1.5 u64
    {1'b1,1'b0,1'b0,3'd2,2'd0,64'hFFF0000000000000,64'h0000000000000000,4'd11}  // R11 -inf u32
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic dp, input logic d64, input logic sg, input logic [2:0] md,
                       input logic [1:0] rm, input logic [63:0] op);
    in_valid = 1'b1; in_fmt_dp = dp; in_dst64 = d64; in_signed = sg;
    in_mode = md; in_rm = rm; in_op = op;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_result == 0 && !out_valid && !out_illegal, "R1 reset", {62'd0, out_valid, out_illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][139], VEC[i][138], VEC[i][137], VEC[i][136:134], VEC[i][133:132], VEC[i][131:68]);
      check(out_valid && !out_illegal && out_result == VEC[i][67:4],
            $sformatf("R%0d vector %0d", VEC[i][3:0], i), out_result, VEC[i][67:4]);
    end

    // R1: one-cycle latency, then idle holds
    apply(1'b1, 1'b1, 1'b1, 3'd0, 2'd0, 64'h4014000000000000);
    check(out_valid && out_result == 64'd5, "R1 latency", out_result, 64'd5);
    @(negedge clk);
    check(!out_valid && !out_illegal && out_result == 64'd5, "R1 idle hold", out_result, 64'd5);

    // R2: illegal modes keep result and raise flag
    apply(1'b1, 1'b1, 1'b1, 3'd6, 2'd0, 64'h4004000000000000);
    check(out_illegal && !out_valid && out_result == 64'd5, "R2 mode 110", out_result, 64'd5);
    apply(1'b1, 1'b0, 1'b0, 3'd7, 2'd2, 64'h7FF8000000000000);
    check(out_illegal && !out_valid && out_result == 64'd5, "R2 mode 111", out_result, 64'd5);
    @(negedge clk);
    check(!out_illegal && !out_valid, "R2 flag drops", {62'd0, out_valid, out_illegal}, 64'd0);

    // R3: upper half ignored for binary32 (all ones above a 2.5)
    apply(1'b0, 1'b1, 1'b1, 3'd1, 2'd0, 64'hFFFFFFFF40200000);
    check(out_result == 64'd2, "R3 upper ignored", out_result, 64'd2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule